// File: doc/BRIEF.md
# Multi-pin GPIO register bank

This block is the register file of a general-purpose I/O controller serving a parameterised number of pins (94 by default). Software reaches it over a simple 32-bit register bus with separate read and write strobes. Reads return data on the clock edge after the strobe. Pin state is kept in two places. The ownership, interrupt-status and interrupt-enable registers are packed bitmaps holding 32 pins per word. Each pin also has its own pair of configuration words, placed at an 8-byte stride.

Towards the pads, the block drives an output enable, an output value and a weak-pull selection for each pin. Every pad input goes through a two-flop synchroniser, and software can read the synchronised level back from the first configuration word. A separate detector block supplies one-cycle hit pulses, which the block latches as interrupt status. It then presents status ANDed with enable for each pin, along with a global routing choice between two upstream interrupt lines.

The word-address decode assumes at most 128 pins, so that the status and enable bitmaps do not overlap. It also assumes the address width covers the last configuration pair.

Top module: `gpio_regbank`

## Requirements
- R1: After reset:
  - every pin is in GPIO mode as an input, with input sensing disabled and pull 0, so config word 1 reads 0x00000005 and config word 2 reads 0x00000004;
  - the ownership bits of existing pins read 1;
  - all status and enable bits read 0;
  - the routing bit reads 0;
  - pad_oe, pad_out, pad_pull and irq_pend are 0.
- R2: A read strobe at a clock edge loads bus_rdata with the addressed word at that edge. bus_rdata holds its value in cycles without a read strobe.
- R3: The map is decoded on bus_addr[AW-1:2] (byte offsets, low two bits ignored):
  - word n of the ownership bitmap is at 0x00+4n;
  - the global control word is at 0x7C;
  - word n of the status bitmap is at 0x80+4n;
  - word n of the enable bitmap is at 0x90+4n;
  - in each bitmap, word n bit b stands for pin 32n+b, and ownership and enable are plain read/write.
- R4: Config word 1 of pin p is at 0x100+8p. Its fields are:
  - bit 31: output level;
  - bit 30: read-only input level;
  - bit 2: direction (1 = input, 0 = output);
  - bit 0: use (1 = GPIO, 0 = native function);
  - all other bits read 0.
- R5: Config word 2 of pin p is at 0x104+8p. Bit 2 disables input sensing when set. Bits 1:0 select the weak pull and appear on pad_pull[2p+1:2p]. All other bits read 0.
- R6: pad_oe[p] is 1 exactly when use is 1 and direction is 0. pad_out[p] equals the output level while pad_oe[p] is 1 and is 0 otherwise. Both follow a config write on the next clock edge.
- R7: pin_level[p] and config word 1 bit 30 show pad_in[p] after a two-flop synchroniser, which is two clock edges of delay. Both read 0 while input sensing is disabled.
- R8: A status bit is set by a pulse on irq_hit[p]. Writing 1 to the bit clears it, and writing 0 leaves it unchanged. When a hit and a clearing write fall in the same cycle, the bit stays set.
- R9: irq_pend[p] is status bit p AND enable bit p.
- R10: Bit 0 of the global control word drives irq_route. Its other bits read 0.
- R11: Unmapped offsets, configuration pairs of pins at or above NPIN, and bitmap bits above NPIN-1 all read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the strobe edge |
| pad_in | input | NPIN | Raw pad input levels |
| pad_oe | output | NPIN | Per-pin output enable |
| pad_out | output | NPIN | Per-pin output value |
| pad_pull | output | 2*NPIN | Weak-pull selection, two bits per pin |
| pin_level | output | NPIN | Synchronised input level, gated by sensing |
| irq_hit | input | NPIN | Event pulses from the interrupt detector |
| irq_pend | output | NPIN | Status AND enable per pin |
| irq_route | output | 1 | Upstream interrupt line selection |

## Verification
The hardest case to reach from the ports is a detector hit that lands in the same cycle as a software write-one-to-clear of that status bit. The bench drives irq_hit and the bus write in one cycle, then reads the status word back and expects the bit still set. A second hard case is the synchroniser delay. The bench flips pad_in at a falling edge, samples pin_level after one and then two rising edges, and expects the old value and then the new one. Out-of-range configuration pairs and the spare top bits of the last bitmap word are written with all ones and read back as zero.

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
  parameter int NPIN = 94,
  parameter int AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [2*NPIN-1:0] pad_pull,
  output logic [NPIN-1:0]   pin_level,
  input  logic [NPIN-1:0]   irq_hit,
  output logic [NPIN-1:0]   irq_pend,
  output logic              irq_route
);

  localparam int NWORD = (NPIN + 31) / 32;
  localparam int WA    = AW - 2;
  localparam int BW    = NWORD * 32;
  localparam logic [WA-1:0] GCTL_W = WA'(31);
  localparam logic [WA-1:0] STAT_W = WA'(32);
  localparam logic [WA-1:0] EN_W   = WA'(36);
  localparam logic [WA-1:0] CFG_W  = WA'(64);

  logic [WA-1:0]   waddr;
  logic [NPIN-1:0] sync1_q, sync2_q;
  logic [BW-1:0]   own_v, stat_v, en_v;
  logic [31:0]     c1_rd [NPIN];
  logic [31:0]     c2_rd [NPIN];
  logic            route_q;
  logic [31:0]     rd_mux;
  logic            rd_hit;

  assign waddr     = bus_addr[AW-1:2];
  assign irq_route = route_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      route_q <= 1'b0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_wr && waddr == GCTL_W) route_q <= bus_wdata[0];
    end
  end

  if (BW > NPIN) begin : g_pad
    assign own_v[BW-1:NPIN]  = '0;
    assign stat_v[BW-1:NPIN] = '0;
    assign en_v[BW-1:NPIN]   = '0;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int WD = p / 32;
    localparam int BT = p % 32;
    logic own_r, st_r, en_r, use_r, dir_r, out_r, sdis_r;
    logic [1:0] pull_r;
    logic w_own, w_st, w_en, w_c1, w_c2;

    assign w_own = bus_wr && waddr == WA'(WD);
    assign w_st  = bus_wr && waddr == STAT_W + WA'(WD);
    assign w_en  = bus_wr && waddr == EN_W + WA'(WD);
    assign w_c1  = bus_wr && waddr == CFG_W + WA'(2*p);
    assign w_c2  = bus_wr && waddr == CFG_W + WA'(2*p + 1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own_r  <= 1'b1;
        st_r   <= 1'b0;
        en_r   <= 1'b0;
        use_r  <= 1'b1;
        dir_r  <= 1'b1;
        out_r  <= 1'b0;
        sdis_r <= 1'b1;
        pull_r <= 2'b00;
      end else begin
        if (w_own) own_r <= bus_wdata[BT];
        if (w_en)  en_r  <= bus_wdata[BT];
        if (irq_hit[p])                st_r <= 1'b1;
        else if (w_st && bus_wdata[BT]) st_r <= 1'b0;
        if (w_c1) begin
          out_r <= bus_wdata[31];
          dir_r <= bus_wdata[2];
          use_r <= bus_wdata[0];
        end
        if (w_c2) begin
          sdis_r <= bus_wdata[2];
          pull_r <= bus_wdata[1:0];
        end
      end
    end

    assign own_v[p]        = own_r;
    assign stat_v[p]       = st_r;
    assign en_v[p]         = en_r;
    assign pad_oe[p]       = use_r & ~dir_r;
    assign pad_out[p]      = out_r & use_r & ~dir_r;
    assign pad_pull[2*p+:2] = pull_r;
    assign pin_level[p]    = sync2_q[p] & ~sdis_r;
    assign irq_pend[p]     = st_r & en_r;
    assign c1_rd[p] = {out_r, pin_level[p], 27'b0, dir_r, 1'b0, use_r};
    assign c2_rd[p] = {29'b0, sdis_r, pull_r};

    AST_OE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      w_c1 |=> pad_oe[p] == ($past(bus_wdata[0]) && !$past(bus_wdata[2]))); // R6
    AST_HIT_RAISES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_hit[p] && en_r && !w_en) |=> irq_pend[p]); // R8
  end

  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b0;
    for (int n = 0; n < NWORD; n++) begin
      if (waddr == WA'(n))          begin rd_mux = own_v[n*32+:32];  rd_hit = 1'b1; end
      if (waddr == STAT_W + WA'(n)) begin rd_mux = stat_v[n*32+:32]; rd_hit = 1'b1; end
      if (waddr == EN_W + WA'(n))   begin rd_mux = en_v[n*32+:32];   rd_hit = 1'b1; end
    end
    if (waddr == GCTL_W) begin rd_mux = {31'b0, route_q}; rd_hit = 1'b1; end
    for (int p = 0; p < NPIN; p++) begin
      if (waddr == CFG_W + WA'(2*p))     begin rd_mux = c1_rd[p]; rd_hit = 1'b1; end
      if (waddr == CFG_W + WA'(2*p + 1)) begin rd_mux = c2_rd[p]; rd_hit = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> bus_rdata == 32'h0); // R11
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R2
  AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && waddr == GCTL_W) |=> $stable(irq_route)); // R10

endmodule

// File: tb/gpio_regbank_tb.sv
`timescale 1ns/1ps
module gpio_regbank_tb_top;
  localparam int NPIN = 94;
  localparam int AW   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPIN-1:0]   pad_in = '0;
  logic [NPIN-1:0]   pad_oe, pad_out, pin_level, irq_pend;
  logic [2*NPIN-1:0] pad_pull;
  logic [NPIN-1:0]   irq_hit = '0;
  logic              irq_route;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_regbank #(.NPIN(NPIN), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull),
    .pin_level(pin_level), .irq_hit(irq_hit), .irq_pend(irq_pend),
    .irq_route(irq_route));

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd === 1'b1) begin
        #2;
        if (exp_q.size() == 0) chk("R2 unexpected read", 32'h1, 32'h0);
        else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe reset", 32'(pad_oe != 0), 32'h0);
    chk("R1 pad_out reset", 32'(pad_out != 0), 32'h0);
    chk("R1 pad_pull reset", 32'(pad_pull != 0), 32'h0);
    chk("R1 irq_pend reset", 32'(irq_pend != 0), 32'h0);
    chk("R1 irq_route reset", 32'(irq_route), 32'h0);
    rd(12'h100, 32'h0000_0005, "R1 R4 cfg1 pin0 reset");
    rd(12'h104, 32'h0000_0004, "R1 R5 cfg2 pin0 reset");
    rd(12'h3E8, 32'h0000_0005, "R1 cfg1 pin93 reset");
    rd(12'h000, 32'hFFFF_FFFF, "R1 R3 own word0 reset");
    rd(12'h008, 32'h3FFF_FFFF, "R1 R11 own word2 reset");
    rd(12'h080, 32'h0, "R1 status reset");
    rd(12'h090, 32'h0, "R1 enable reset");

    // R2: rdata holds without a strobe
    repeat (3) @(negedge clk);
    chk("R2 rdata hold", bus_rdata, 32'h0);

    wr(12'h128, 32'h8000_0001);
    chk("R6 oe pin5", 32'(pad_oe[5]), 32'h1);
    chk("R6 out pin5", 32'(pad_out[5]), 32'h1);
    rd(12'h128, 32'h8000_0001, "R4 cfg1 pin5 readback");
    wr(12'h138, 32'h8000_0000);
    chk("R6 native pin7 oe", 32'(pad_oe[7]), 32'h0);
    chk("R6 native pin7 out", 32'(pad_out[7]), 32'h0);
    wr(12'h148, 32'hFFFF_FFFF);
    chk("R6 input pin9 oe", 32'(pad_oe[9]), 32'h0);
    rd(12'h148, 32'h8000_0005, "R4 R7 cfg1 pin9 sensing off");

    pad_in[9] = 1'b1;
    wr(12'h14C, 32'hFFFF_FFF3);
    chk("R5 pull pin9", 32'(pad_pull[19:18]), 32'h3);
    rd(12'h14C, 32'h0000_0003, "R5 cfg2 pin9 readback");
    repeat (2) @(negedge clk);
    rd(12'h148, 32'hC000_0005, "R7 input level high");
    pad_in[9] = 1'b0;
    @(negedge clk);
    chk("R7 sync stage1 still old", 32'(pin_level[9]), 32'h1);
    @(negedge clk);
    chk("R7 sync stage2 new", 32'(pin_level[9]), 32'h0);
    pad_in[9] = 1'b1;
    wr(12'h14C, 32'h0000_0004);
    repeat (3) @(negedge clk);
    chk("R7 sensing disabled level", 32'(pin_level[9]), 32'h0);
    rd(12'h148, 32'h8000_0005, "R7 sensing disabled bit30");

    @(negedge clk); irq_hit[40] = 1'b1;
    @(negedge clk); irq_hit[40] = 1'b0;
    rd(12'h084, 32'h0000_0100, "R8 status set by hit");
    chk("R9 pend masked", 32'(irq_pend[40]), 32'h0);
    wr(12'h094, 32'h0000_0100);
    chk("R9 pend enabled", 32'(irq_pend[40]), 32'h1);
    rd(12'h094, 32'h0000_0100, "R3 enable readback");
    wr(12'h084, 32'h0000_0000);
    rd(12'h084, 32'h0000_0100, "R8 write zero keeps");
    wr(12'h084, 32'h0000_0100);
    rd(12'h084, 32'h0, "R8 write one clears");
    chk("R9 pend cleared", 32'(irq_pend[40]), 32'h0);
    @(negedge clk);
    bus_addr = 12'h084; bus_wdata = 32'h0000_0100; bus_wr = 1'b1; irq_hit[40] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_hit[40] = 1'b0;
    rd(12'h084, 32'h0000_0100, "R8 set wins over clear");

    wr(12'h07C, 32'hFFFF_FFFF);
    chk("R10 route set", 32'(irq_route), 32'h1);
    rd(12'h07C, 32'h0000_0001, "R10 gctl readback");

    wr(12'h3F0, 32'hFFFF_FFFF);
    rd(12'h3F0, 32'h0, "R11 pin94 cfg1 absent");
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, 32'h0, "R11 unmapped read");
    wr(12'h098, 32'hFFFF_FFFF);
    rd(12'h098, 32'h3FFF_FFFF, "R11 spare enable bits");
    wr(12'h000, 32'h0000_FFFF);
    rd(12'h000, 32'h0000_FFFF, "R3 own word0 write");
    rd(12'h100, 32'h0000_0005, "R11 pin0 untouched");

    repeat (3) @(negedge clk);
    chk("R2 all reads answered", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule